// File: doc/BRIEF.md
# Ranged-Event State Address Sequencer

This block sits between the event source of a memory-monitoring unit and its state lookup path. Every data word owns a small packed state entry of 1, 2 or 4 bits. These entries are stored back to back in a state region that starts at a programmable base byte address. The block accepts one event request at a time. A request is a single-word event, a doubleword event, or a ranged event that carries a start byte address and a byte count.

The block splits each request into one-word steps and issues one step per accepted output beat. For each step it reports three things: the data word address, the byte address of the state byte that holds that word's entry, and the bit position of the entry inside that byte. The state width and the base address are sampled when a request is accepted, and the whole sequence uses those sampled values.

Top module: `st_range_seq`

## Requirements
- R1: `cfg_width` is read as an unsigned bit count. The values 1, 2 and 4 select that many state bits per word. Any other value selects 4 bits and drives `cfg_err` high; `cfg_err` is low for 1, 2 and 4.
- R2: For a data word at byte address A, `out_state_addr` = base + (A >> S), where S is 5, 4 or 3 for 1-, 2- or 4-bit state. Example: with 2-bit state, base 0xF0000000 and A = 0xABCD, the result is 0xF0000ABC.
- R3: `out_bit_off` = ((A >> 2) mod (8 / width)) * width, where width is the state width in bits.
- R4: A request with `req_kind` = 2'b00 yields exactly one beat. That beat carries word address `{req_addr[31:2], 2'b00}` and has `out_last` set.
- R5: A request with `req_kind` = 2'b01 yields two beats: the word holding `req_addr`, then the next word.
- R6: A request with `req_kind[1]` = 1 is ranged. It yields one beat per word, in ascending order, from word `req_addr >> 2` through word `(req_addr + req_size - 1) >> 2`, using 32-bit wraparound. Every word the range partially touches is included.
- R7: A ranged request with `req_size` = 0 yields no beats. `req_ready` is high again on the next cycle.
- R8: `req_ready` is high only while no sequence is in progress. A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- R9: `out_last` is high on the final beat of a sequence and on no other beat. After that beat is accepted, `out_valid` falls.
- R10: While `out_valid` is high and `out_ready` is low, all output fields stay unchanged.
- R11: A change to `cfg_width` or `cfg_base` after a request is accepted has no effect on that request's beats.
- R12: `out_code` equals the `req_code` of the request being expanded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 3 | State bits per word (1, 2 or 4) |
| cfg_base | input | 32 | Byte address where the state region starts |
| cfg_err | output | 1 | `cfg_width` holds an unsupported value |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and can take a request |
| req_kind | input | 2 | 00 word, 01 doubleword, 1x ranged |
| req_code | input | 6 | Event type code, passed through |
| req_addr | input | 32 | Start data byte address |
| req_size | input | 16 | Byte count for ranged requests |
| out_valid | output | 1 | A word step is presented |
| out_ready | input | 1 | The lookup path takes the step |
| out_code | output | 6 | Event type code of the step |
| out_word_addr | output | 32 | Data word byte address (low two bits zero) |
| out_state_addr | output | 32 | Byte address of the state byte |
| out_bit_off | output | 3 | Bit position of the entry within the state byte |
| out_last | output | 1 | Final step of the sequence |

## Verification
The hold and step assertions take for granted that the downstream side may stall at any time. They also assume the request side keeps its fields steady only on the cycle of the handshake. The stimulus drives `out_ready` randomly with frequent stalls, pulses `req_valid` for one cycle only while `req_ready` is high, and keeps ranged sizes small enough that every sequence finishes within its budget. Illegal width codes and configuration changes in the middle of a sequence are deliberately mixed into the random stream. This keeps each sequence checked against the width it latched and not against the live setting.

// File: rtl/st_seq_pkg.sv
package st_seq_pkg;

    // Decoded state width selection.
    typedef enum logic [1:0] {
        SW_1 = 2'd0,
        SW_2 = 2'd1,
        SW_4 = 2'd2
    } swidth_e;

    localparam int NUM_WIDTHS = 3;

    // Request kind encodings: bit 1 set means ranged.
    localparam logic [1:0] KIND_WORD  = 2'b00;
    localparam logic [1:0] KIND_DWORD = 2'b01;

endpackage

// File: rtl/st_width_decode.sv
module st_width_decode
    import st_seq_pkg::*;
(
    input  logic [2:0] width_raw,
    output swidth_e    wsel,
    output logic       bad
);

    always_comb begin
        bad = 1'b0;
        unique case (width_raw)
            3'd1:    wsel = SW_1;
            3'd2:    wsel = SW_2;
            3'd4:    wsel = SW_4;
            default: begin
                wsel = SW_4;
                bad  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/st_addr_map.sv
module st_addr_map
    import st_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int WIDX_W = ADDR_W - 2
)(
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [ADDR_W-1:0] base,
    input  swidth_e           wsel,
    output logic [ADDR_W-1:0] state_addr,
    output logic [2:0]        bit_off
);

    logic [ADDR_W-1:0] cand_addr [NUM_WIDTHS];
    logic [2:0]        cand_off  [NUM_WIDTHS];

    // Option g holds 2**g bits per word, so 2**(3-g) entries share a byte.
    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        localparam int IDX_BITS = 3 - g;
        localparam logic [2:0] LOW_MASK = 3'((1 << IDX_BITS) - 1);

        logic [2:0] low_idx;

        always_comb begin
            low_idx      = word_idx[2:0] & LOW_MASK;
            cand_off[g]  = 3'(low_idx << g);
            cand_addr[g] = base + ADDR_W'(word_idx >> IDX_BITS);
        end
    end

    always_comb begin
        unique case (wsel)
            SW_1:    begin state_addr = cand_addr[0]; bit_off = cand_off[0]; end
            SW_2:    begin state_addr = cand_addr[1]; bit_off = cand_off[1]; end
            default: begin state_addr = cand_addr[2]; bit_off = cand_off[2]; end
        endcase
    end

endmodule

// File: rtl/st_word_walker.sv
module st_word_walker
    import st_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int CODE_W = 6,
    localparam int WIDX_W = ADDR_W - 2,
    localparam int CNT_W  = SIZE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  swidth_e           live_wsel,
    input  logic [ADDR_W-1:0] live_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [CODE_W-1:0] req_code,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              busy,
    input  logic              step_take,
    output logic [WIDX_W-1:0] cur_word,
    output logic [CODE_W-1:0] cur_code,
    output swidth_e           cur_wsel,
    output logic [ADDR_W-1:0] cur_base,
    output logic              cur_last
);

    typedef struct packed {
        logic              busy;
        logic [WIDX_W-1:0] word;
        logic [CNT_W-1:0]  left;
        logic [CODE_W-1:0] code;
        swidth_e           wsel;
        logic [ADDR_W-1:0] base;
    } walk_s;

    walk_s st_d, st_q;

    logic [ADDR_W-1:0] end_byte;
    logic [WIDX_W-1:0] span;
    logic [CNT_W-1:0]  req_cnt;

    // Number of words a request covers.
    always_comb begin
        end_byte = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
        span     = end_byte[ADDR_W-1:2] - req_addr[ADDR_W-1:2];
        if (req_kind[1]) begin
            req_cnt = (req_size == '0) ? '0 : CNT_W'(span) + CNT_W'(1);
        end else if (req_kind == KIND_DWORD) begin
            req_cnt = CNT_W'(2);
        end else begin
            req_cnt = CNT_W'(1);
        end
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy = (req_cnt != '0);
                st_d.word = req_addr[ADDR_W-1:2];
                st_d.left = req_cnt;
                st_d.code = req_code;
                st_d.wsel = live_wsel;
                st_d.base = live_base;
            end
        end else if (step_take) begin
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.left = '0;
            end else begin
                st_d.word = st_q.word + WIDX_W'(1);
                st_d.left = st_q.left - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, word: '0, left: '0, code: '0,
                      wsel: SW_1, base: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.busy;
    assign busy      = st_q.busy;
    assign cur_word  = st_q.word;
    assign cur_code  = st_q.code;
    assign cur_wsel  = st_q.wsel;
    assign cur_base  = st_q.base;
    assign cur_last  = (st_q.left == CNT_W'(1));

    // R8: no request is taken while a sequence is in progress
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R10: a stalled step holds still
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step_take |=> busy && $stable(cur_word) && $stable(cur_last)
                               && $stable(cur_code) && $stable(cur_base));

    // R6: non-final steps advance by one word
    assert_step_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step_take && !cur_last |=> busy && cur_word == $past(cur_word) + WIDX_W'(1));

    // R9: the final step ends the sequence
    assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step_take && cur_last |=> !busy);

endmodule

// File: rtl/st_range_seq.sv
module st_range_seq
    import st_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int CODE_W = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_width,
    input  logic [ADDR_W-1:0] cfg_base,
    output logic              cfg_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [CODE_W-1:0] req_code,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] out_code,
    output logic [ADDR_W-1:0] out_word_addr,
    output logic [ADDR_W-1:0] out_state_addr,
    output logic [2:0]        out_bit_off,
    output logic              out_last
);

    localparam int WIDX_W = ADDR_W - 2;

    swidth_e           live_wsel;
    swidth_e           cur_wsel;
    logic [ADDR_W-1:0] cur_base;
    logic [WIDX_W-1:0] cur_word;
    logic              busy;

    st_width_decode u_dec (
        .width_raw (cfg_width),
        .wsel      (live_wsel),
        .bad       (cfg_err)
    );

    st_word_walker #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .CODE_W (CODE_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_wsel (live_wsel),
        .live_base (cfg_base),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_code  (req_code),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .busy      (busy),
        .step_take (out_ready),
        .cur_word  (cur_word),
        .cur_code  (out_code),
        .cur_wsel  (cur_wsel),
        .cur_base  (cur_base),
        .cur_last  (out_last)
    );

    st_addr_map #(
        .ADDR_W (ADDR_W)
    ) u_map (
        .word_idx   (cur_word),
        .base       (cur_base),
        .wsel       (cur_wsel),
        .state_addr (out_state_addr),
        .bit_off    (out_bit_off)
    );

    assign out_valid     = busy;
    assign out_word_addr = {cur_word, 2'b00};

    // R3: a 4-bit entry starts on a nibble boundary
    assert_off_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cur_wsel == SW_4 |-> out_bit_off[1:0] == 2'b00);

    // R3: a 2-bit entry starts on an even bit
    assert_off_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cur_wsel == SW_2 |-> out_bit_off[0] == 1'b0);

endmodule

// File: tb/st_range_seq_tb.sv
module st_range_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_width;
    logic [31:0] cfg_base;
    logic        cfg_err;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_kind;
    logic [5:0]  req_code;
    logic [31:0] req_addr;
    logic [15:0] req_size;
    logic        out_valid;
    logic        out_ready;
    logic [5:0]  out_code;
    logic [31:0] out_word_addr;
    logic [31:0] out_state_addr;
    logic [2:0]  out_bit_off;
    logic        out_last;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    st_range_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_base(cfg_base),
        .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_code(req_code), .req_addr(req_addr),
        .req_size(req_size), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code), .out_word_addr(out_word_addr),
        .out_state_addr(out_state_addr), .out_bit_off(out_bit_off),
        .out_last(out_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff_w(input logic [2:0] raw);
        return (raw == 3'd1 || raw == 3'd2 || raw == 3'd4) ? int'(raw) : 4;
    endfunction

    function automatic logic [31:0] exp_state(input logic [31:0] base, input logic [31:0] wa, input int w);
        int sh = (w == 1) ? 5 : (w == 2) ? 4 : 3;
        return base + (wa >> sh);
    endfunction

    function automatic logic [2:0] exp_off(input logic [31:0] wa, input int w);
        int per = 8 / w;
        return 3'(((wa >> 2) % per) * w);
    endfunction

    function automatic int exp_count(input logic [1:0] k, input logic [31:0] a, input logic [15:0] s);
        logic [31:0] e;
        if (k == 2'b00) return 1;
        if (k == 2'b01) return 2;
        if (s == 16'd0) return 0;
        e = a + 32'(s) - 32'd1;
        return int'((e >> 2) - (a >> 2)) + 1;
    endfunction

    // Issue one request; optionally disturb the configuration after acceptance.
    task automatic run_req(input logic [1:0] k, input logic [5:0] code, input logic [31:0] a,
                           input logic [15:0] s, input bit disturb, input int rdy_pct);
        int          n;
        int          w;
        int          got;
        int          guard;
        logic [31:0] base;
        logic [31:0] wa;
        bit          stalled;
        logic [31:0] h_sa;
        logic [2:0]  h_off;
        logic        h_last;
        w    = eff_w(cfg_width);
        base = cfg_base;
        n    = exp_count(k, a, s);
        @(negedge clk);
        check("R8 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_kind = k; req_code = code; req_addr = a; req_size = s;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = $urandom; req_size = 16'($urandom); req_code = 6'($urandom);
        if (disturb) begin
            cfg_width = 3'($urandom);
            cfg_base  = $urandom;
        end
        got = 0; guard = 0; stalled = 1'b0;
        h_sa = '0; h_off = '0; h_last = 1'b0;
        while (got < n && guard < 2000) begin
            out_ready = (($urandom % 100) < rdy_pct);
            #1;
            if (stalled) begin
                check("R10 stalled state addr held", out_state_addr, h_sa);
                check("R10 stalled bit off held", 32'(out_bit_off), 32'(h_off));
                check("R10 stalled last held", 32'(out_last), 32'(h_last));
            end
            check("R6 valid during sequence", 32'(out_valid), 32'd1);
            check("R8 ready low while busy", 32'(req_ready), 32'd0);
            wa = ((a & 32'hFFFF_FFFC) + 32'(got) * 32'd4);
            if (out_ready) begin
                check("R4 R5 R6 word addr", out_word_addr, wa);
                check("R2 R11 state addr", out_state_addr, exp_state(base, wa, w));
                check("R3 R11 bit offset", 32'(out_bit_off), 32'(exp_off(wa, w)));
                check("R9 last flag", 32'(out_last), 32'(got == n - 1));
                check("R12 code", 32'(out_code), 32'(code));
                got++;
                stalled = 1'b0;
            end else begin
                stalled = 1'b1;
                h_sa = out_state_addr; h_off = out_bit_off; h_last = out_last;
            end
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) check("watchdog sequence finished", 32'd0, 32'd1);
        out_ready = 1'b0;
        #1;
        check("R7 R9 idle after sequence", 32'(out_valid), 32'd0);
        check("R7 R9 ready after sequence", 32'(req_ready), 32'd1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0;
        req_kind = '0; req_code = '0; req_addr = '0; req_size = '0;
        cfg_width = 3'd2; cfg_base = 32'hF000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 reset ready", 32'(req_ready), 32'd1);
        check("R9 reset valid low", 32'(out_valid), 32'd0);

        // R2 worked example: 2-bit state, base 0xF0000000, address 0xABCD
        req_valid = 1'b1; req_kind = 2'b00; req_addr = 32'h0000_ABCD; req_code = 6'd5;
        @(negedge clk);
        req_valid = 1'b0; out_ready = 1'b1;
        #1;
        check("R2 example state addr", out_state_addr, 32'hF000_0ABC);
        check("R3 example bit offset", 32'(out_bit_off), 32'd6);
        check("R4 single word last", 32'(out_last), 32'd1);
        @(negedge clk);
        out_ready = 1'b0;

        // R1 width decode, including illegal codes
        for (int v = 0; v < 8; v++) begin
            cfg_width = 3'(v);
            #1;
            check("R1 cfg_err", 32'(cfg_err), 32'(!(v == 1 || v == 2 || v == 4)));
        end
        cfg_width = 3'd7; cfg_base = 32'h1000_0000;
        run_req(2'b10, 6'd9, 32'h0000_0100, 16'd40, 1'b0, 70);  // R1 illegal acts as 4 bits

        // Directed corners
        cfg_width = 3'd1; cfg_base = 32'h2000_0000;
        run_req(2'b10, 6'd1, 32'h0000_1003, 16'd2, 1'b0, 100);   // R6 straddles two words
        run_req(2'b10, 6'd2, 32'h0000_2000, 16'd0, 1'b0, 100);   // R7 empty range
        run_req(2'b11, 6'd3, 32'h0000_3001, 16'd1, 1'b0, 50);    // R6 one byte
        run_req(2'b01, 6'd4, 32'hFFFF_FFFC, 16'd0, 1'b0, 50);    // R5 doubleword wraps
        cfg_width = 3'd4;
        run_req(2'b10, 6'd6, 32'h0000_4000, 16'd64, 1'b1, 60);   // R11 cfg moves mid-sequence
        run_req(2'b00, 6'd7, 32'h0000_5557, 16'd99, 1'b0, 30);   // R4 size ignored

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  k = 2'($urandom);
            logic [15:0] s;
            if (($urandom % 10) == 0) s = 16'd0;
            else if (($urandom % 8) == 0) s = 16'($urandom % 400);
            else s = 16'($urandom % 48);
            case ($urandom % 5)
                0: cfg_width = 3'd1;
                1: cfg_width = 3'd2;
                2: cfg_width = 3'd4;
                default: cfg_width = 3'($urandom);
            endcase
            cfg_base = $urandom;
            run_req(k, 6'($urandom), $urandom, s, (($urandom % 4) == 0), 40 + int'($urandom % 61));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule